// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block gathers the interrupt events of a multi-channel DMA engine into one set of software-visible registers and a single interrupt line. Every physical channel can report three kinds of event as one-cycle pulses: transfer done, error of the first class and error of the second class. Each kind has its own pending register that latches the pulses, its own enable register, and a read-only view of the pending bits that are enabled. A combined view shows, per channel, whether any enabled event is pending. The OR of the combined view drives the interrupt output through one register stage.

Software clears pending events by writing ones to the pending register of that kind. The pending registers sit at a separate, higher address range from the enabled views. The controller also shows the live per-channel busy inputs in a read-only register. Bit i of every register belongs to physical channel i. The bus is a simple select/write/address/data port. Read data is combinational in the cycle of the read, and writes take effect at the next clock edge.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After synchronous reset every pending and enable register reads zero and `irq` is low.
- R2: A pulse on bit i of `ev_done`, `ev_err1` or `ev_err2` sets bit i of the pending register at 0x600, 0x608 or 0x610 respectively at the next clock edge. The bit stays set until software clears it.
- R3: A write to a pending register (0x600, 0x608, 0x610) clears each bit that has a one in the write data and leaves the other bits unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The enable registers at 0x18 (done), 0x20 (error 1) and 0x24 (error 2) store the low NUM_CH bits of the written data and read them back. Upper bits read zero, and a one enables that channel.
- R6: The read-only enabled views at 0x04 (done), 0x0C (error 1) and 0x10 (error 2) read as the pending bits ANDed with the enable bits of the same kind.
- R7: The combined register at 0x00 has bit i set when any of the three enabled views has bit i set.
- R8: `irq` is high in the cycle after a cycle in which the combined status was nonzero, and low otherwise.
- R9: The register at 0x690 reads the current `ch_busy` input. Writes to 0x00, 0x04, 0x0C, 0x10 and 0x690 change nothing.
- R10: Reads of any other offset return zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid while a read is selected, else zero |
| ev_done | input | NUM_CH (16) | Per-channel transfer-done pulses |
| ev_err1 | input | NUM_CH (16) | Per-channel error class 1 pulses |
| ev_err2 | input | NUM_CH (16) | Per-channel error class 2 pulses |
| ch_busy | input | NUM_CH (16) | Per-channel active level |
| irq | output | 1 | Registered interrupt request |

## Verification
The event-capture path and the software clear path can meet on the same pending bit in the same cycle. The bench provokes this by driving a done pulse on channel 0 in the cycle of a clearing write of 0x5 to 0x600, while channel 2 is already pending. It then reads back 0x600 and expects 0x1: the new event survives and the old one is removed. The same scoreboard also follows the enable and clear traffic through the enabled views, the combined register and the one-cycle-late interrupt line.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int N_KIND = 3;

    typedef enum logic [1:0] {
        K_DONE = 2'd0,
        K_ERR1 = 2'd1,
        K_ERR2 = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_COMB,
        SRC_VIEW,
        SRC_ENABLE,
        SRC_PEND,
        SRC_BUSY
    } rd_src_e;

    typedef struct packed {
        rd_src_e     src;
        logic [1:0]  kind;
    } rd_sel_t;

    typedef struct packed {
        logic [N_KIND-1:0] clr_we;
        logic [N_KIND-1:0] en_we;
    } wr_stb_t;

    localparam logic [11:0] OFF_COMB = 12'h000;
    localparam logic [11:0] OFF_BUSY = 12'h690;

    function automatic logic [11:0] view_off(input int k);
        case (k)
            0:       return 12'h004;
            1:       return 12'h00C;
            default: return 12'h010;
        endcase
    endfunction

    function automatic logic [11:0] enable_off(input int k);
        case (k)
            0:       return 12'h018;
            1:       return 12'h020;
            default: return 12'h024;
        endcase
    endfunction

    function automatic logic [11:0] pend_off(input int k);
        case (k)
            0:       return 12'h600;
            1:       return 12'h608;
            default: return 12'h610;
        endcase
    endfunction

endpackage

// File: rtl/dirq_decode.sv
module dirq_decode
    import dirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_stb_t           wstb,
    output rd_sel_t           rsel
);

    always_comb begin
        wstb      = '0;
        rsel.src  = SRC_NONE;
        rsel.kind = 2'd0;
        if (bus_sel) begin
            for (int k = 0; k < N_KIND; k++) begin
                if (bus_addr == ADDR_W'(pend_off(k)))
                    wstb.clr_we[k] = bus_wr;
                if (bus_addr == ADDR_W'(enable_off(k)))
                    wstb.en_we[k] = bus_wr;
            end
            if (!bus_wr) begin
                if (bus_addr == ADDR_W'(OFF_COMB)) begin
                    rsel.src = SRC_COMB;
                end else if (bus_addr == ADDR_W'(OFF_BUSY)) begin
                    rsel.src = SRC_BUSY;
                end else begin
                    for (int k = 0; k < N_KIND; k++) begin
                        if (bus_addr == ADDR_W'(view_off(k))) begin
                            rsel.src  = SRC_VIEW;
                            rsel.kind = 2'(k);
                        end
                        if (bus_addr == ADDR_W'(enable_off(k))) begin
                            rsel.src  = SRC_ENABLE;
                            rsel.kind = 2'(k);
                        end
                        if (bus_addr == ADDR_W'(pend_off(k))) begin
                            rsel.src  = SRC_PEND;
                            rsel.kind = 2'(k);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dirq_bank.sv
module dirq_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev_pulse,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] pend_q,
    output logic [NUM_CH-1:0] enable_q,
    output logic [NUM_CH-1:0] view
);

    logic [NUM_CH-1:0] clr_bits;
    logic [NUM_CH-1:0] pend_d;

    assign clr_bits = clr_we ? wbits : '0;
    // a new event overrides a clear of the same bit
    assign pend_d   = (pend_q & ~clr_bits) | ev_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            enable_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (en_we)
                enable_q <= wbits;
        end
    end

    assign view = pend_q & enable_q;

endmodule

// File: rtl/dirq_rdmux.sv
module dirq_rdmux
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  rd_sel_t                        rsel,
    input  logic [N_KIND-1:0][NUM_CH-1:0]  pend_v,
    input  logic [N_KIND-1:0][NUM_CH-1:0]  enable_v,
    input  logic [N_KIND-1:0][NUM_CH-1:0]  view_v,
    input  logic [NUM_CH-1:0]              comb_stat,
    input  logic [NUM_CH-1:0]              busy,
    output logic [DATA_W-1:0]              rdata
);

    logic [NUM_CH-1:0] pick;

    always_comb begin
        pick = '0;
        for (int k = 0; k < N_KIND; k++) begin
            if (rsel.kind == 2'(k)) begin
                case (rsel.src)
                    SRC_VIEW:   pick = view_v[k];
                    SRC_ENABLE: pick = enable_v[k];
                    SRC_PEND:   pick = pend_v[k];
                    default:    ;
                endcase
            end
        end
        case (rsel.src)
            SRC_COMB: pick = comb_stat;
            SRC_BUSY: pick = busy;
            SRC_NONE: pick = '0;
            default:  ;
        endcase
        rdata = DATA_W'(pick);
    end

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_err1,
    input  logic [NUM_CH-1:0] ev_err2,
    input  logic [NUM_CH-1:0] ch_busy,
    output logic              irq
);

    wr_stb_t                        wstb;
    rd_sel_t                        rsel;
    logic [N_KIND-1:0][NUM_CH-1:0]  ev_all;
    logic [N_KIND-1:0][NUM_CH-1:0]  pend_v;
    logic [N_KIND-1:0][NUM_CH-1:0]  enable_v;
    logic [N_KIND-1:0][NUM_CH-1:0]  view_v;
    logic [NUM_CH-1:0]              comb_stat;
    logic                           irq_q;

    assign ev_all = {ev_err2, ev_err1, ev_done};

    dirq_decode #(.ADDR_W(ADDR_W)) i_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wstb     (wstb),
        .rsel     (rsel)
    );

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        dirq_bank #(.NUM_CH(NUM_CH)) i_bank (
            .clk      (clk),
            .rst      (rst),
            .ev_pulse (ev_all[k]),
            .clr_we   (wstb.clr_we[k]),
            .en_we    (wstb.en_we[k]),
            .wbits    (bus_wdata[NUM_CH-1:0]),
            .pend_q   (pend_v[k]),
            .enable_q (enable_v[k]),
            .view     (view_v[k])
        );
    end

    always_comb begin
        comb_stat = '0;
        for (int k = 0; k < N_KIND; k++)
            comb_stat = comb_stat | view_v[k];
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |comb_stat;
    end

    assign irq = irq_q;

    dirq_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_rdmux (
        .rsel      (rsel),
        .pend_v    (pend_v),
        .enable_v  (enable_v),
        .view_v    (view_v),
        .comb_stat (comb_stat),
        .busy      (ch_busy),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/dirq_checker.sv
module dirq_checker
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [NUM_CH-1:0]             ev_done,
    input logic [NUM_CH-1:0]             ev_err1,
    input logic [NUM_CH-1:0]             ev_err2,
    input logic                          irq,
    input logic [N_KIND-1:0][NUM_CH-1:0] pend_v,
    input logic [N_KIND-1:0][NUM_CH-1:0] enable_v
);

    logic [N_KIND-1:0][NUM_CH-1:0] ev_seen;
    logic [N_KIND-1:0][NUM_CH-1:0] clr_seen;
    logic                          en_write;
    logic                          known_addr;
    logic [11:0]                   a12;

    assign ev_seen = {ev_err2, ev_err1, ev_done};
    assign a12     = 12'(bus_addr);

    always_comb begin
        clr_seen = '0;
        if (bus_sel && bus_wr) begin
            if (a12 == 12'h600) clr_seen[0] = bus_wdata[NUM_CH-1:0];
            if (a12 == 12'h608) clr_seen[1] = bus_wdata[NUM_CH-1:0];
            if (a12 == 12'h610) clr_seen[2] = bus_wdata[NUM_CH-1:0];
        end
    end

    assign en_write = bus_sel && bus_wr &&
                      (a12 == 12'h018 || a12 == 12'h020 || a12 == 12'h024);

    always_comb begin
        case (a12)
            12'h000, 12'h004, 12'h00C, 12'h010,
            12'h018, 12'h020, 12'h024,
            12'h600, 12'h608, 12'h610, 12'h690: known_addr = 1'b1;
            default:                            known_addr = 1'b0;
        endcase
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!irq && pend_v == '0 && enable_v == '0));

    // R2 R4
    event_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_seen != '0) |=> ((pend_v & $past(ev_seen)) == $past(ev_seen)));

    // R3
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_v) & ~pend_v & ~$past(clr_seen)) == '0));

    // R5
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_write |=> $stable(enable_v));

    // R8
    irq_delay_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == (|($past(pend_v) & $past(enable_v)))));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !known_addr) |-> (bus_rdata == '0));

endmodule

bind dma_irq_aggregator dirq_checker #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) i_dirq_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_done   (ev_done),
    .ev_err1   (ev_err1),
    .ev_err2   (ev_err2),
    .irq       (irq),
    .pend_v    (pend_v),
    .enable_v  (enable_v)
);

// File: tb/test_dma_irq_aggregator.sv
module test_dma_irq_aggregator;

    localparam int NUM_CH = 16;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NUM_CH-1:0] ev_done = '0;
    logic [NUM_CH-1:0] ev_err1 = '0;
    logic [NUM_CH-1:0] ev_err2 = '0;
    logic [NUM_CH-1:0] ch_busy = '0;
    logic              irq;

    typedef struct {
        logic [31:0] exp;
        string       tag;
        bit          is_irq;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic     probe = 1'b0;
    int       checks = 0;
    int       errors = 0;
    bit       finished = 1'b0;

    always #2 clk = ~clk;

    dma_irq_aggregator #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dma_irq_aggregator (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ev_done   (ev_done),
        .ev_err1   (ev_err1),
        .ev_err2   (ev_err2),
        .ch_busy   (ch_busy),
        .irq       (irq)
    );

    // monitor: compares each probed cycle against the front of the queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (probe && sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        sb_q.push_back('{exp: e, tag: t, is_irq: 1'b0});
        probe    = 1'b1;
        @(negedge clk);
        bus_sel  = 1'b0;
        probe    = 1'b0;
    endtask

    task automatic expect_irq(input logic e, input string t);
        @(negedge clk);
        sb_q.push_back('{exp: {31'b0, e}, tag: t, is_irq: 1'b1});
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic pulse(input int kind, input logic [NUM_CH-1:0] v);
        @(negedge clk);
        case (kind)
            0:       ev_done = v;
            1:       ev_err1 = v;
            default: ev_err2 = v;
        endcase
        @(negedge clk);
        ev_done = '0;
        ev_err1 = '0;
        ev_err2 = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd(12'h000, 32'h0, "R1 combined after reset");
        expect_rd(12'h600, 32'h0, "R1 done pending after reset");
        expect_rd(12'h018, 32'h0, "R1 done enable after reset");
        expect_irq(1'b0, "R1 irq after reset");

        // R5 enable registers, upper bits read zero
        bus_write(12'h018, 32'h0000_FFFF);
        bus_write(12'h020, 32'h0000_00F0);
        bus_write(12'h024, 32'hFFFF_FFFF);
        expect_rd(12'h018, 32'h0000_FFFF, "R5 done enable readback");
        expect_rd(12'h020, 32'h0000_00F0, "R5 err1 enable readback");
        expect_rd(12'h024, 32'h0000_FFFF, "R5 err2 enable upper bits zero");

        // R2 R6 R7 R8 done events
        pulse(0, 16'h0005);
        expect_rd(12'h600, 32'h0005, "R2 done pending set");
        expect_rd(12'h004, 32'h0005, "R6 done view");
        expect_rd(12'h000, 32'h0005, "R7 combined after done");
        expect_irq(1'b1, "R8 irq raised");

        // R2 R6 error kinds with partial enable
        pulse(1, 16'h0102);
        expect_rd(12'h608, 32'h0102, "R2 err1 pending set");
        expect_rd(12'h00C, 32'h0000, "R6 err1 view masked off");
        pulse(2, 16'h8000);
        expect_rd(12'h610, 32'h8000, "R2 err2 pending set");
        expect_rd(12'h010, 32'h8000, "R6 err2 view");
        expect_rd(12'h000, 32'h8005, "R7 combined of three kinds");
        expect_rd(12'h600, 32'h0005, "R2 done pending held");

        // R3 write-one-to-clear
        bus_write(12'h600, 32'h0000_0001);
        expect_rd(12'h600, 32'h0004, "R3 partial clear of done");
        bus_write(12'h608, 32'h0000_FFFF);
        expect_rd(12'h608, 32'h0000, "R3 full clear of err1");
        bus_write(12'h610, 32'h0000_8000);
        expect_rd(12'h610, 32'h0000, "R3 clear of err2");
        expect_rd(12'h000, 32'h0004, "R7 combined after clears");

        // R4 event and clear on the same bit in the same cycle
        @(negedge clk);
        ev_done   = 16'h0001;
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = 12'h600;
        bus_wdata = 32'h0000_0005;
        @(negedge clk);
        ev_done   = '0;
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
        expect_rd(12'h600, 32'h0001, "R4 set wins over clear");

        // R6 R8 disabling the only enabled kind drops irq
        bus_write(12'h018, 32'h0);
        expect_rd(12'h004, 32'h0000, "R6 done view after disable");
        expect_rd(12'h000, 32'h0000, "R7 combined after disable");
        expect_irq(1'b0, "R8 irq dropped");
        expect_rd(12'h600, 32'h0001, "R6 pending kept while disabled");

        // R9 busy register and read-only writes
        @(negedge clk);
        ch_busy = 16'hA5A5;
        expect_rd(12'h690, 32'h0000_A5A5, "R9 busy readback");
        bus_write(12'h690, 32'hFFFF_FFFF);
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h00C, 32'hFFFF_FFFF);
        expect_rd(12'h600, 32'h0001, "R9 pending untouched by read-only writes");
        expect_rd(12'h018, 32'h0000, "R9 done enable untouched");
        expect_rd(12'h020, 32'h00F0, "R9 err1 enable untouched");
        expect_rd(12'h690, 32'h0000_A5A5, "R9 busy unaffected by write");

        // R10 unmapped offsets
        expect_rd(12'h008, 32'h0, "R10 read 0x008");
        expect_rd(12'h014, 32'h0, "R10 read 0x014");
        expect_rd(12'h604, 32'h0, "R10 read 0x604");
        expect_rd(12'h7FC, 32'h0, "R10 read 0x7FC");
        bus_write(12'h01C, 32'hFFFF_FFFF);
        bus_write(12'h604, 32'hFFFF_FFFF);
        expect_rd(12'h018, 32'h0000, "R10 enable untouched by unmapped write");
        expect_rd(12'h600, 32'h0001, "R10 pending untouched by unmapped write");
        expect_irq(1'b0, "R10 irq unchanged");

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule